// File: doc/BRIEF.md
# MDIO Management Master with Command Register and PHY Scan

This block is a clause-22 MDIO management master. Software talks to it through one 32-bit command/status word. Writing a word that asks for a read or a write makes the block emit one complete management frame. The frame has a long run of 1 bits, a start code, an opcode, a PHY address, a register address, a turnaround and 16 data bits. The block drives MDC, MDIO out and the MDIO output enable, and it samples MDIO in during read data. When a frame finishes, a completion bit is set. For reads, the result is placed in the low half of the status word.

A bus-scan sequencer can also drive the frame engine. It reads the identifier register at PHY addresses 0, 1, 2 and upward, and stops at the first address whose value is neither all zeros nor all ones. If no address qualifies, it reports not-found and falls back to a default address. Only one frame is ever in flight. A command or scan request that arrives while the engine or the scan is busy is dropped. The MDC half period is a parameter counted in system clocks, so it can be set to keep MDC at or below 2.5 MHz.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, mdc and mdio_oe are 0, cmd_rdata is 0, scan_addr is 1, and scan_busy, scan_found and scan_notfound are 0. Every frame starts with exactly PRE_LEN (35) driven 1 bits, followed by the start code 0 then 1. mdio_oe is 0 whenever no frame is in flight.
- R2: A write frame carries opcode 0,1, then the 5-bit PHY address and the 5-bit register address, each MSB first. The turnaround is driven as 1 then 0, followed by the 16 write data bits MSB first. mdio_oe stays 1 for the whole write frame.
- R3: A read frame carries opcode 1,0, then the addresses. mdio_oe drops to 0 from the first turnaround bit to the end of the frame. The 16 data bits on mdio_i are sampled MSB first while mdc is high. The result appears in cmd_rdata[15:0].
- R4: In a command word, bits 25:21 hold the PHY address and bits 20:16 the register address. Bit 27 requests a read and bit 26 a write; if both are set the command is a read. Bits 15:0 hold the write data. A word with neither bit 27 nor bit 26 set starts no frame and changes nothing. cmd_rdata[27:16] echoes bits 27:16 of the last accepted command, and cmd_rdata[15:0] holds its write data until a read result replaces it.
- R5: cmd_rdata[28] is the completion bit. It reads 0 in the cycle after a command is accepted and becomes 1 when that command's frame ends, for both reads and writes.
- R6: A command written while a frame is in flight or a scan is running is ignored: no extra frame is sent and cmd_rdata[27:16] does not change.
- R7: mdc is low for DIV_HALF clocks and then high for DIV_HALF clocks in each bit time. mdio_o and mdio_oe change only at the start of the low half.
- R8: A scan_start pulse on an idle block starts a scan with scan_busy at 1. The scan reads register ID_REG (3) at addresses 0 upward, one frame per address, and stops at the first address whose value is neither 16'h0000 nor 16'hFFFF. It then sets scan_found and puts that address on scan_addr.
- R9: If no address out of NPHY (32) qualifies, the scan ends after NPHY frames with scan_notfound set and scan_addr at DEF_PHY (1). scan_found and scan_notfound are never 1 together, and both are 0 while the scan runs.
- R10: A scan_start pulse that arrives while a command frame is in flight is ignored: scan_busy stays 0 and no scan frames follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word (fields per R4) |
| cmd_rdata | output | 32 | Status word: completion bit 28, echoed fields 27:16, data 15:0 |
| scan_start | input | 1 | Pulse to begin a PHY bus scan |
| scan_busy | output | 1 | Scan in progress |
| scan_found | output | 1 | Scan ended on a qualifying address |
| scan_notfound | output | 1 | Scan ended without a qualifying address |
| scan_addr | output | 5 | Address chosen by the last scan |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pin |

## Verification
The hardest situation to reach from the ports is a collision: a command or a scan request arriving while the single frame engine is already in use. This covers a command during a command frame, a command in the middle of a multi-frame scan, and a scan request during a command frame. The bench models a PHY that decodes every frame from mdc and mdio_o and answers reads on mdio_i. It then places these colliding requests at fixed cycle offsets inside running frames and counts the frames that come out. The scan end conditions are reached by moving the one answering address across the first, second, middle and last positions, and by leaving no address that answers.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int CMD_W     = 32;
  // command / status word field positions (software decodes these)
  localparam int F_DONE    = 28;
  localparam int F_RD      = 27;
  localparam int F_WR      = 26;
  localparam int F_PHY_LSB = 21;
  localparam int F_REG_LSB = 16;
  localparam int FLD_W     = F_DONE - F_REG_LSB;

  typedef struct packed {
    logic              rd;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regad;
    logic [DATA_W-1:0] wdata;
  } mdio_req_t;
endpackage

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_HALF = 20,
  parameter int PRE_LEN  = 35
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  mdio_req_t         req,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int FRAME   = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int CW      = $clog2(FRAME);
  localparam int DW      = $clog2(DIV_HALF + 1);
  localparam int DAT_POS = FRAME - DATA_W;
  localparam int REL_LEN = DATA_W + 2;

  logic [FRAME-1:0] frame_w, oe_w, sh_q, oesh_q;
  logic [CW-1:0]    bitc_q;
  logic [DW-1:0]    divc_q;
  logic             rd_q;

  // serial image of the frame, first bit in the top position
  always_comb begin
    frame_w = {{PRE_LEN{1'b1}}, 2'b01,
               (req.rd ? 2'b10 : 2'b01),
               req.phy, req.regad,
               (req.rd ? 2'b11 : 2'b10),
               (req.rd ? {DATA_W{1'b1}} : req.wdata)};
    oe_w    = req.rd ? {{(FRAME-REL_LEN){1'b1}}, {REL_LEN{1'b0}}}
                     : {FRAME{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      mdc     <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      bitc_q  <= '0;
      divc_q  <= '0;
      sh_q    <= '0;
      oesh_q  <= '0;
      rd_q    <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          rd_q    <= req.rd;
          sh_q    <= frame_w;
          oesh_q  <= oe_w;
          bitc_q  <= '0;
          divc_q  <= '0;
          mdc     <= 1'b0;
          mdio_o  <= frame_w[FRAME-1];
          mdio_oe <= oe_w[FRAME-1];
        end
      end else if (divc_q != DW'(DIV_HALF - 1)) begin
        divc_q <= divc_q + 1'b1;
      end else begin
        divc_q <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
        end else begin
          mdc <= 1'b0;
          // last clock of the high half: sample read data
          if (rd_q && (bitc_q >= CW'(DAT_POS)))
            rd_data <= {rd_data[DATA_W-2:0], mdio_i};
          if (bitc_q == CW'(FRAME - 1)) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b1;
          end else begin
            bitc_q  <= bitc_q + 1'b1;
            mdio_o  <= sh_q[FRAME-2];
            mdio_oe <= oesh_q[FRAME-2];
            sh_q    <= {sh_q[FRAME-2:0], 1'b0};
            oesh_q  <= {oesh_q[FRAME-2:0], 1'b0};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_cmd_reg.sv
module mdio_cmd_reg
  import mdio_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [CMD_W-1:0]  wdata,
  input  logic              allow,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              start,
  output mdio_req_t         req,
  output logic [CMD_W-1:0]  rdata
);
  logic [FLD_W-1:0]  fld_q;
  logic [DATA_W-1:0] dat_q;
  logic              done_q, own_q;

  assign start     = wr && allow && (wdata[F_RD] || wdata[F_WR]);
  assign req.rd    = wdata[F_RD];
  assign req.phy   = wdata[F_PHY_LSB +: PHY_W];
  assign req.regad = wdata[F_REG_LSB +: REG_W];
  assign req.wdata = wdata[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q  <= '0;
      dat_q  <= '0;
      done_q <= 1'b0;
      own_q  <= 1'b0;
    end else begin
      if (eng_done && own_q) begin
        own_q  <= 1'b0;
        done_q <= 1'b1;
        if (fld_q[F_RD-F_REG_LSB]) dat_q <= eng_rdata;
      end
      if (start) begin
        own_q  <= 1'b1;
        done_q <= 1'b0;
        fld_q  <= wdata[F_REG_LSB +: FLD_W];
        dat_q  <= wdata[DATA_W-1:0];
      end
    end
  end

  always_comb begin
    rdata                          = '0;
    rdata[F_DONE]                  = done_q;
    rdata[F_REG_LSB +: FLD_W]      = fld_q;
    rdata[DATA_W-1:0]              = dat_q;
  end
endmodule

// File: rtl/mdio_scan_seq.sv
module mdio_scan_seq
  import mdio_mgmt_pkg::*;
#(
  parameter int NPHY    = 32,
  parameter int ID_REG  = 3,
  parameter int DEF_PHY = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              allow,
  input  logic              eng_done,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              issue,
  output mdio_req_t         req,
  output logic              busy,
  output logic              found,
  output logic              notfound,
  output logic [PHY_W-1:0]  addr
);
  localparam int IW = $clog2(NPHY);

  logic [IW-1:0] idx_q;
  logic          valid_id;

  assign valid_id  = (eng_rdata != '0) && (eng_rdata != '1);
  assign req.rd    = 1'b1;
  assign req.phy   = PHY_W'(idx_q);
  assign req.regad = REG_W'(ID_REG);
  assign req.wdata = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      issue    <= 1'b0;
      idx_q    <= '0;
      found    <= 1'b0;
      notfound <= 1'b0;
      addr     <= PHY_W'(DEF_PHY);
    end else begin
      issue <= 1'b0;
      if (!busy) begin
        if (go && allow) begin
          busy     <= 1'b1;
          issue    <= 1'b1;
          idx_q    <= '0;
          found    <= 1'b0;
          notfound <= 1'b0;
        end
      end else if (eng_done) begin
        if (valid_id) begin
          found <= 1'b1;
          addr  <= PHY_W'(idx_q);
          busy  <= 1'b0;
        end else if (idx_q == IW'(NPHY - 1)) begin
          notfound <= 1'b1;
          addr     <= PHY_W'(DEF_PHY);
          busy     <= 1'b0;
        end else begin
          idx_q <= idx_q + 1'b1;
          issue <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_HALF = 20,
  parameter int PRE_LEN  = 35,
  parameter int NPHY     = 32,
  parameter int ID_REG   = 3,
  parameter int DEF_PHY  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  output logic [CMD_W-1:0] cmd_rdata,
  input  logic             scan_start,
  output logic             scan_busy,
  output logic             scan_found,
  output logic             scan_notfound,
  output logic [PHY_W-1:0] scan_addr,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic              eng_busy, eng_done, eng_start;
  logic [DATA_W-1:0] eng_rdata;
  logic              cmd_start, scan_issue;
  mdio_req_t         cmd_req, scan_req, eng_req;

  // command path has priority; scan blocks commands while it runs
  assign eng_start = cmd_start || scan_issue;
  assign eng_req   = scan_issue ? scan_req : cmd_req;

  mdio_cmd_reg u_cmd (
    .clk(clk), .rst(rst), .wr(cmd_wr), .wdata(cmd_wdata),
    .allow(!eng_busy && !scan_busy),
    .eng_done(eng_done), .eng_rdata(eng_rdata),
    .start(cmd_start), .req(cmd_req), .rdata(cmd_rdata)
  );

  mdio_scan_seq #(.NPHY(NPHY), .ID_REG(ID_REG), .DEF_PHY(DEF_PHY)) u_scan (
    .clk(clk), .rst(rst), .go(scan_start),
    .allow(!eng_busy && !cmd_start),
    .eng_done(eng_done), .eng_rdata(eng_rdata),
    .issue(scan_issue), .req(scan_req), .busy(scan_busy),
    .found(scan_found), .notfound(scan_notfound), .addr(scan_addr)
  );

  mdio_frame_eng #(.DIV_HALF(DIV_HALF), .PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .req(eng_req),
    .mdio_i(mdio_i), .busy(eng_busy), .done(eng_done),
    .rd_data(eng_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_wr,
  input logic [31:0] cmd_wdata,
  input logic [31:0] cmd_rdata,
  input logic        scan_busy,
  input logic        scan_found,
  input logic        scan_notfound,
  input logic [4:0]  scan_addr,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        eng_busy
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !eng_busy |-> (!mdio_oe && !mdc));

  p_out_hold_high_r7: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_done_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !eng_busy && !scan_busy && (cmd_wdata[27] || cmd_wdata[26]))
      |=> !cmd_rdata[28]);

  p_ignore_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && (eng_busy || scan_busy)) |=> $stable(cmd_rdata[27:16]));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(scan_found && scan_notfound));

  p_flags_clear_r8: assert property (@(posedge clk) disable iff (rst)
    scan_busy |-> (!scan_found && !scan_notfound));

  p_default_addr_r9: assert property (@(posedge clk) disable iff (rst)
    scan_notfound |-> (scan_addr == 5'd1));
endmodule

bind mdio_mgmt_master mdio_mgmt_chk chk_i (
  .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
  .cmd_rdata(cmd_rdata), .scan_busy(scan_busy), .scan_found(scan_found),
  .scan_notfound(scan_notfound), .scan_addr(scan_addr), .mdc(mdc),
  .mdio_o(mdio_o), .mdio_oe(mdio_oe), .eng_busy(eng_busy)
);

// File: tb/mdio_mgmt_master_tb_top.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        scan_start = 1'b0;
  logic        scan_busy, scan_found, scan_notfound;
  logic [4:0]  scan_addr;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #5 clk = ~clk;

  mdio_mgmt_master #(.DIV_HALF(DIV)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .scan_start(scan_start), .scan_busy(scan_busy),
    .scan_found(scan_found), .scan_notfound(scan_notfound),
    .scan_addr(scan_addr), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  int n_chk = 0;
  int n_err = 0;
  int scan_hit = 99;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] phy_resp(input logic [4:0] p, input logic [4:0] r);
    if (r == 5'd3) begin
      if (int'(p) == scan_hit) return 16'h0100 + {11'd0, p};
      return p[0] ? 16'h0000 : 16'hFFFF;
    end
    return 16'(int'(p) * 1237) ^ 16'(int'(r) * 4099) ^ 16'h5A3C;
  endfunction

  // ---------------- PHY model: decodes frames, answers reads ----------------
  int          ones = 0, k = 0, nframes = 0, f_pre = 0;
  bit          infr = 0, f_bad = 0;
  logic [1:0]  f_op, f_ta;
  logic [4:0]  f_phy, f_reg;
  logic [15:0] f_dat, resp;
  time         last_rise = 0;

  always @(posedge mdc) begin
    if (infr && (($time - last_rise) != 2 * DIV * 10)) f_bad = 1;
    last_rise = $time;
    if (!infr) begin
      if (mdio_oe && mdio_o) ones++;
      else if (mdio_oe && !mdio_o && ones >= 32) begin
        infr = 1; k = 0; f_pre = ones; ones = 0; f_bad = 0;
        f_op = '0; f_phy = '0; f_reg = '0; f_ta = '0; f_dat = '0;
      end else ones = 0;
    end else begin
      k++;
      if (k == 1 && mdio_o !== 1'b1) f_bad = 1;
      if (k >= 14 && f_op == 2'b10) begin
        if (mdio_oe !== 1'b0) f_bad = 1;
      end else if (mdio_oe !== 1'b1) f_bad = 1;
      if (k >= 2 && k <= 3)   f_op  = {f_op[0], mdio_o};
      if (k >= 4 && k <= 8)   f_phy = {f_phy[3:0], mdio_o};
      if (k >= 9 && k <= 13)  f_reg = {f_reg[3:0], mdio_o};
      if (k == 13)            resp  = phy_resp(f_phy, f_reg);
      if (k >= 14 && k <= 15) f_ta  = {f_ta[0], mdio_o};
      if (k >= 16 && k <= 31) f_dat = {f_dat[14:0], mdio_o};
      if (k == 31) begin infr = 0; nframes++; ones = 0; end
    end
  end

  always @(negedge mdc) begin
    if (infr && f_op == 2'b10 && k >= 15 && k <= 30) mdio_i = resp[30-k];
    else mdio_i = 1'b1;
  end

  // ---------------- helpers ----------------
  task automatic do_cmd(input logic [31:0] w);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_wr = 1'b0;
  endtask

  task automatic pulse_scan();
    @(negedge clk); scan_start = 1'b1;
    @(negedge clk); scan_start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (cmd_rdata[28]) break;
    end
  endtask

  task automatic wait_scan();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!scan_busy) break;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  logic [31:0] cmd, snap;
  logic [4:0]  pa, ra;
  logic [15:0] dv;
  int          base, exp_n, exp_a;
  int          hits [7] = '{0, 1, 5, 17, 30, 31, 99};

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R10 reset state
    chk("R1 reset mdc", mdc, 0);
    chk("R1 reset oe", mdio_oe, 0);
    chk("R1 reset rdata", cmd_rdata, 0);
    chk("R1 reset scan_addr", scan_addr, 1);
    chk("R10 reset scan flags", {scan_busy, scan_found, scan_notfound}, 0);

    // R2 write sweep over all PHY addresses
    for (int p = 0; p < 32; p++) begin
      pa = 5'(p); ra = 5'(31 - p);
      dv = 16'(p * 16'h0421) ^ 16'hC3A5;
      cmd = {4'b0000, 1'b0, 1'b1, pa, ra, dv};
      base = nframes;
      do_cmd(cmd);
      chk("R5 done clears on accept", cmd_rdata[28], 0);
      wait_done();
      chk("R2 one frame", nframes, base + 1);
      chk("R2 write opcode", f_op, 2'b01);
      chk("R2 phy addr", f_phy, pa);
      chk("R2 reg addr", f_reg, ra);
      chk("R2 turnaround", f_ta, 2'b10);
      chk("R2 data", f_dat, dv);
      chk("R1 preamble length", f_pre, 35);
      chk("R7 timing and enables", f_bad, 0);
      chk("R4 R5 status word", cmd_rdata, cmd | 32'h1000_0000);
    end

    // R3 read sweep over all register addresses
    for (int r = 0; r < 32; r++) begin
      ra = 5'(r); pa = 5'((r * 7) % 32);
      cmd = {4'b0000, 1'b1, 1'b0, pa, ra, 16'h0000};
      base = nframes;
      do_cmd(cmd);
      wait_done();
      chk("R3 one frame", nframes, base + 1);
      chk("R3 read opcode", f_op, 2'b10);
      chk("R3 release and timing", f_bad, 0);
      chk("R3 result word", cmd_rdata, {4'b0001, 1'b1, 1'b0, pa, ra, phy_resp(pa, ra)});
    end

    // R4 both request bits: read wins
    pa = 5'd12; ra = 5'd6;
    cmd = {4'b0000, 1'b1, 1'b1, pa, ra, 16'h7777};
    do_cmd(cmd);
    wait_done();
    chk("R4 both bits -> read opcode", f_op, 2'b10);
    chk("R4 both bits result", cmd_rdata[15:0], phy_resp(pa, ra));

    // R4 neither bit: ignored
    snap = cmd_rdata; base = nframes;
    do_cmd({6'b000000, 5'd9, 5'd4, 16'hBEEF});
    repeat (400) @(negedge clk);
    chk("R4 no-op frames", nframes, base);
    chk("R4 no-op status", cmd_rdata, snap);
    chk("R1 idle oe", mdio_oe, 0);

    // R6 / R10 collisions with a running command frame
    base = nframes;
    cmd = {4'b0000, 1'b0, 1'b1, 5'd7, 5'd2, 16'h1111};
    do_cmd(cmd);
    repeat (30) @(negedge clk);
    do_cmd({4'b0000, 1'b0, 1'b1, 5'd20, 5'd9, 16'h2222});
    pulse_scan();
    chk("R10 scan start ignored while busy", scan_busy, 0);
    wait_done();
    repeat (400) @(negedge clk);
    chk("R6 only one frame", nframes, base + 1);
    chk("R6 frame is first command", f_phy, 5'd7);
    chk("R6 status keeps first command", cmd_rdata[27:0], cmd[27:0]);
    chk("R10 no scan ran", {scan_busy, scan_found, scan_notfound}, 0);

    // R6 command during a scan
    scan_hit = 5; snap = cmd_rdata; base = nframes;
    pulse_scan();
    repeat (50) @(negedge clk);
    do_cmd({4'b0000, 1'b0, 1'b1, 5'd3, 5'd3, 16'h3333});
    wait_scan();
    chk("R6 scan frames only", nframes, base + 6);
    chk("R6 status untouched by scan", cmd_rdata, snap);
    chk("R8 found during collision", scan_addr, 5);

    // R8 / R9 scan sweep over hit positions
    foreach (hits[i]) begin
      scan_hit = hits[i];
      base = nframes;
      pulse_scan();
      chk("R8 scan busy after start", scan_busy, 1);
      wait_scan();
      exp_n = (scan_hit < 32) ? scan_hit + 1 : 32;
      exp_a = (scan_hit < 32) ? scan_hit : 1;
      chk("R8 frame count", nframes, base + exp_n);
      chk("R8 id register", f_reg, 3);
      chk("R8 read opcode", f_op, 2'b10);
      chk("R8 last address probed", f_phy, (scan_hit < 32) ? scan_hit : 31);
      chk("R8 R9 found flag", scan_found, (scan_hit < 32) ? 1 : 0);
      chk("R9 notfound flag", scan_notfound, (scan_hit < 32) ? 0 : 1);
      chk("R8 R9 scan address", scan_addr, exp_a);
    end

    summary();
    $finish;
  end
endmodule